// File: doc/BRIEF.md
# SPI Flash Command Engine

A register-mapped master that runs one serial-flash command at a time over a single-bit SPI link in mode 0. The host sets an opcode byte and a byte that packs the transmit and receive counts. It loads payload bytes through one data port into an 8-slot ring buffer and then sets a start bit. The engine pulls chip select low and shifts out the opcode, the payload bytes taken from the ring starting at the current pointer, and then one all-zero byte for each byte to be received.

The opcode never passes through the ring. Every later byte stores the byte received in its time slot back into the ring slot it used, and the pointer then moves on. The ring is never cleared and the pointer is visible to the host. To collect results, the host rewinds the pointer, reads past the echoed transmit slots and then reads the response bytes through the same port. A two-bit field selects the SCK half-period as one to four clock cycles.

Top module: `spi_cmd_engine`

## Requirements
- R1: Offset 0x0 holds the opcode. Offset 0x1 holds the receive count in bits 7:4 and the transmit payload count, which excludes the opcode, in bits 3:0. Both read back what was written.
- R2: Offset 0xC is the data port. A write stores into the ring slot at the pointer and a read returns that slot. Each access then advances the pointer by one, modulo 8. Bits 2:0 of offset 0xD show the pointer.
- R3: Writing 1 to bit 4 of offset 0x2 sets the pointer to 0. If bit 0 is set in the same write, the transaction uses the cleared pointer.
- R4: Writing 1 to bit 0 of offset 0x2 starts a transaction. That bit reads 1 while the transaction runs and 0 once it has finished.
- R5: A start is refused when the transmit count exceeds 5 or the receive count exceeds 8. In that case chip select stays high and the busy bit stays 0.
- R6: The serial output is the opcode, then the payload from ring slots starting at the pointer, then 0x00 for each receive byte. Bits go MSB first. MOSI changes only while SCK is low.
- R7: Each byte after the opcode writes its received byte into the slot it used, and the pointer advances. The final pointer is (start + transmit + receive) mod 8, wrapping over older slots.
- R8: Bits 5:4 of offset 0xD select the SCK half-period, which is the field value plus one clock cycles.
- R9: Chip select is active low. It falls one half-period before the first SCK rise and rises on the final SCK fall. SCK is low whenever chip select is high.
- R10: While a transaction runs, the engine ignores data port accesses, pointer clears and writes to offsets 0x0, 0x1 and 0xD.
- R11: After reset, chip select is high, SCK and MOSI are low, and the pointer, speed field and busy bit are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 4 | Register byte offset |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe; advances the pointer at the data port |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i, combinational |
| spi_sck_o | output | 1 | Serial clock |
| spi_cs_no | output | 1 | Chip select, active low |
| spi_mosi_o | output | 1 | Serial data to the flash |
| spi_miso_i | input | 1 | Serial data from the flash |

## Verification
Two pairs of actions can land on the same clock edge. The first pair is a host data-port access or pointer clear and the engine's write-back of a received byte, which both target the ring and the pointer. The bench provokes this by issuing port writes, port reads, pointer clears, speed writes and opcode writes while a slow transaction runs. It then judges the outcome from the final pointer, the speed and opcode readback, and a full dump of the ring compared against a shadow model. The second pair is a pointer clear and a start issued in one write. The bench starts with the pointer away from zero and checks that the payload is taken from slot 0 onward.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  typedef enum logic {ENG_IDLE, ENG_SHIFT} eng_state_e;

  localparam logic [3:0] OFS_OPC = 4'h0;
  localparam logic [3:0] OFS_CNT = 4'h1;
  localparam logic [3:0] OFS_CTL = 4'h2;
  localparam logic [3:0] OFS_DAT = 4'hC;
  localparam logic [3:0] OFS_STS = 4'hD;

  localparam int unsigned CTL_GO   = 0;
  localparam int unsigned CTL_PCLR = 4;
  localparam int unsigned STS_SPD  = 4;
endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [SEL_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_ring.sv
module spi_ring #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned DW    = 8,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  output logic [DW-1:0] rdata_a_o,
  input  logic [AW-1:0] raddr_b_i,
  output logic [DW-1:0] rdata_b_o
);
  logic [DEPTH-1:0][DW-1:0] slot_w;

  // storage is deliberately never cleared
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [DW-1:0] q;
    always_ff @(posedge clk_i) begin
      if (we_i && (waddr_i == AW'(g))) q <= wdata_i;
    end
    assign slot_w[g] = q;
  end

  assign rdata_a_o = slot_w[raddr_a_i];
  assign rdata_b_o = slot_w[raddr_b_i];
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter
  import spi_cmd_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned CNT_W = 4,
  localparam int unsigned BIT_W = $clog2(DW)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [DW-1:0]    opc_i,
  input  logic [CNT_W-1:0] tx_cnt_i,
  input  logic [CNT_W-1:0] rx_cnt_i,
  input  logic             tick_i,
  input  logic [DW-1:0]    cur_byte_i,
  input  logic [DW-1:0]    nxt_byte_i,
  input  logic             miso_i,
  output logic             busy_o,
  output logic             sck_o,
  output logic             cs_no,
  output logic             mosi_o,
  output logic             slot_we_o,
  output logic [DW-1:0]    slot_wdata_o
);
  eng_state_e       st_q;
  logic [BIT_W-1:0] bit_q;
  logic [DW-1:0]    sh_tx_q, sh_rx_q;
  logic             in_op_q, sck_q;
  logic [CNT_W-1:0] tx_left_q;
  logic [CNT_W:0]   byte_left_q;
  logic             byte_end, last_byte;

  assign busy_o       = (st_q == ENG_SHIFT);
  assign cs_no        = !busy_o;
  assign sck_o        = sck_q;
  assign mosi_o       = busy_o && sh_tx_q[DW-1];
  assign byte_end     = busy_o && tick_i && sck_q && (bit_q == BIT_W'(DW-1));
  assign slot_we_o    = byte_end && !in_op_q;
  assign slot_wdata_o = sh_rx_q;
  assign last_byte    = in_op_q ? (byte_left_q == '0) : (byte_left_q == (CNT_W+1)'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ENG_IDLE;
      bit_q       <= '0;
      sh_tx_q     <= '0;
      sh_rx_q     <= '0;
      in_op_q     <= 1'b0;
      sck_q       <= 1'b0;
      tx_left_q   <= '0;
      byte_left_q <= '0;
    end else begin
      case (st_q)
        ENG_IDLE: begin
          sck_q <= 1'b0;
          if (go_i) begin
            st_q        <= ENG_SHIFT;
            sh_tx_q     <= opc_i;
            bit_q       <= '0;
            in_op_q     <= 1'b1;
            tx_left_q   <= tx_cnt_i;
            byte_left_q <= {1'b0, tx_cnt_i} + {1'b0, rx_cnt_i};
          end
        end
        ENG_SHIFT: begin
          if (tick_i) begin
            if (!sck_q) begin
              sck_q   <= 1'b1;
              sh_rx_q <= {sh_rx_q[DW-2:0], miso_i};
            end else begin
              sck_q <= 1'b0;
              if (bit_q != BIT_W'(DW-1)) begin
                bit_q   <= bit_q + 1'b1;
                sh_tx_q <= {sh_tx_q[DW-2:0], 1'b0};
              end else begin
                bit_q   <= '0;
                in_op_q <= 1'b0;
                if (!in_op_q) byte_left_q <= byte_left_q - 1'b1;
                if (last_byte) begin
                  st_q    <= ENG_IDLE;
                  sh_tx_q <= '0;
                end else if (tx_left_q != '0) begin
                  // pointer moves on this edge unless the opcode just ended
                  sh_tx_q   <= in_op_q ? cur_byte_i : nxt_byte_i;
                  tx_left_q <= tx_left_q - 1'b1;
                end else begin
                  sh_tx_q <= '0;
                end
              end
            end
          end
        end
        default: st_q <= ENG_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int unsigned DW         = 8,
  parameter int unsigned AW         = 4,
  parameter int unsigned RING_DEPTH = 8,
  parameter int unsigned CNT_W      = 4,
  parameter int unsigned SPD_W      = 2,
  parameter int unsigned MAX_TX     = 5,
  parameter int unsigned MAX_RX     = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] bus_addr_i,
  input  logic          bus_wr_i,
  input  logic          bus_rd_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          spi_sck_o,
  output logic          spi_cs_no,
  output logic          spi_mosi_o,
  input  logic          spi_miso_i
);
  localparam int unsigned PTR_W = $clog2(RING_DEPTH);
  localparam logic [CNT_W-1:0] TX_LIM = CNT_W'(MAX_TX);
  localparam logic [CNT_W-1:0] RX_LIM = CNT_W'(MAX_RX);

  logic [DW-1:0]    opc_q;
  logic [CNT_W-1:0] tx_cnt_q, rx_cnt_q;
  logic [SPD_W-1:0] spd_q;
  logic [PTR_W-1:0] ptr_q;

  logic busy, tick, go, pclr, dat_wr, dat_rd;
  logic eng_we;
  logic [DW-1:0] eng_wdata, cur_byte, nxt_byte;
  logic ring_we;
  logic [DW-1:0] ring_wdata;

  assign go     = bus_wr_i && (bus_addr_i == AW'(OFS_CTL)) && bus_wdata_i[CTL_GO] && !busy
                  && (tx_cnt_q <= TX_LIM) && (rx_cnt_q <= RX_LIM);
  assign pclr   = bus_wr_i && (bus_addr_i == AW'(OFS_CTL)) && bus_wdata_i[CTL_PCLR] && !busy;
  assign dat_wr = bus_wr_i && (bus_addr_i == AW'(OFS_DAT)) && !busy;
  assign dat_rd = bus_rd_i && (bus_addr_i == AW'(OFS_DAT)) && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opc_q    <= '0;
      tx_cnt_q <= '0;
      rx_cnt_q <= '0;
      spd_q    <= '0;
    end else if (bus_wr_i && !busy) begin
      if (bus_addr_i == AW'(OFS_OPC)) opc_q <= bus_wdata_i;
      if (bus_addr_i == AW'(OFS_CNT)) begin
        tx_cnt_q <= bus_wdata_i[CNT_W-1:0];
        rx_cnt_q <= bus_wdata_i[CNT_W +: CNT_W];
      end
      if (bus_addr_i == AW'(OFS_STS)) spd_q <= bus_wdata_i[STS_SPD +: SPD_W];
    end
  end

  // clear wins; host and engine never step the pointer together
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          ptr_q <= '0;
    else if (pclr)                        ptr_q <= '0;
    else if (dat_wr || dat_rd || eng_we)  ptr_q <= ptr_q + 1'b1;
  end

  assign ring_we    = dat_wr || eng_we;
  assign ring_wdata = eng_we ? eng_wdata : bus_wdata_i;

  spi_ring #(.DEPTH(RING_DEPTH), .DW(DW)) i_ring (
    .clk_i     (clk_i),
    .we_i      (ring_we),
    .waddr_i   (ptr_q),
    .wdata_i   (ring_wdata),
    .raddr_a_i (ptr_q),
    .rdata_a_o (cur_byte),
    .raddr_b_i (ptr_q + 1'b1),
    .rdata_b_o (nxt_byte)
  );

  spi_clk_div #(.SEL_W(SPD_W)) i_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (busy),
    .sel_i  (spd_q),
    .tick_o (tick)
  );

  spi_shifter #(.DW(DW), .CNT_W(CNT_W)) i_shift (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .go_i         (go),
    .opc_i        (opc_q),
    .tx_cnt_i     (tx_cnt_q),
    .rx_cnt_i     (rx_cnt_q),
    .tick_i       (tick),
    .cur_byte_i   (cur_byte),
    .nxt_byte_i   (nxt_byte),
    .miso_i       (spi_miso_i),
    .busy_o       (busy),
    .sck_o        (spi_sck_o),
    .cs_no        (spi_cs_no),
    .mosi_o       (spi_mosi_o),
    .slot_we_o    (eng_we),
    .slot_wdata_o (eng_wdata)
  );

  always_comb begin
    bus_rdata_o = '0;
    case (bus_addr_i)
      AW'(OFS_OPC): bus_rdata_o = opc_q;
      AW'(OFS_CNT): begin
        bus_rdata_o[CNT_W-1:0]     = tx_cnt_q;
        bus_rdata_o[CNT_W +: CNT_W] = rx_cnt_q;
      end
      AW'(OFS_CTL): bus_rdata_o[CTL_GO] = busy;
      AW'(OFS_DAT): bus_rdata_o = cur_byte;
      AW'(OFS_STS): begin
        bus_rdata_o[PTR_W-1:0]      = ptr_q;
        bus_rdata_o[STS_SPD +: SPD_W] = spd_q;
      end
      default: bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk #(
  parameter int unsigned DW     = 8,
  parameter int unsigned AW     = 4,
  parameter int unsigned PTR_W  = 3,
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned SPD_W  = 2,
  parameter int unsigned MAX_TX = 5,
  parameter int unsigned MAX_RX = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [AW-1:0]    bus_addr_i,
  input logic             bus_wr_i,
  input logic [DW-1:0]    bus_wdata_i,
  input logic             spi_sck_o,
  input logic             spi_cs_no,
  input logic             spi_mosi_o,
  input logic             busy,
  input logic [PTR_W-1:0] ptr,
  input logic [SPD_W-1:0] spd,
  input logic [CNT_W-1:0] tx_cnt,
  input logic [CNT_W-1:0] rx_cnt
);
  localparam logic [CNT_W-1:0] TX_LIM = CNT_W'(MAX_TX);
  localparam logic [CNT_W-1:0] RX_LIM = CNT_W'(MAX_RX);

  logic start_req, cnt_ok;
  assign start_req = bus_wr_i && (bus_addr_i == AW'(2)) && bus_wdata_i[0] && !busy;
  assign cnt_ok    = (tx_cnt <= TX_LIM) && (rx_cnt <= RX_LIM);

  AST_SCK_NEEDS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_cs_no |-> !spi_sck_o); // R9
  AST_MOSI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_sck_o |-> $stable(spi_mosi_o)); // R6
  AST_PTR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ptr != $past(ptr)) |-> ((ptr == $past(ptr) + 1'b1) || (ptr == '0))); // R2
  AST_GO_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_req && cnt_ok) |=> !spi_cs_no); // R4
  AST_GO_REFUSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_req && !cnt_ok) |=> spi_cs_no); // R5
  AST_SPD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy)) |-> $stable(spd)); // R10
endmodule

bind spi_cmd_engine spi_cmd_engine_chk #(
  .DW(DW), .AW(AW), .PTR_W($clog2(RING_DEPTH)), .CNT_W(CNT_W), .SPD_W(SPD_W),
  .MAX_TX(MAX_TX), .MAX_RX(MAX_RX)
) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_addr_i  (bus_addr_i),
  .bus_wr_i    (bus_wr_i),
  .bus_wdata_i (bus_wdata_i),
  .spi_sck_o   (spi_sck_o),
  .spi_cs_no   (spi_cs_no),
  .spi_mosi_o  (spi_mosi_o),
  .busy        (busy),
  .ptr         (ptr_q),
  .spd         (spd_q),
  .tx_cnt      (tx_cnt_q),
  .rx_cnt      (rx_cnt_q)
);

// File: tb/test_spi_cmd_engine.sv
`timescale 1ns/1ps
module test_spi_cmd_engine;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       sck, cs_n, mosi;
  logic       miso = 1'b0;

  int checks = 0, fails = 0;
  logic [7:0] exp_q[$];
  logic [7:0] got_q[$];
  logic [7:0] ring_m[8];
  int         ptr_m = 0;
  int         spd_m = 0;
  logic [7:0] seed = 8'h00;

  int   rb = 0, bytec = 0;
  logic [7:0] shin = '0;
  realtime t_csf, t_r1, t_f1, t_lastfall, t_csrise;
  bit   first = 0;

  always #2.5 clk = ~clk;

  spi_cmd_engine i_spi_cmd_engine (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .spi_sck_o(sck), .spi_cs_no(cs_n),
    .spi_mosi_o(mosi), .spi_miso_i(miso)
  );

  function automatic logic [7:0] resp(int k);
    logic [7:0] t;
    t = 8'(k * 37);
    return t ^ seed ^ 8'hC3;
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // flash model
  always @(negedge cs_n) begin
    rb = 0; bytec = 0;
    miso = resp(0)[7];
    t_csf = $realtime; first = 1;
  end
  always @(posedge sck) begin
    if (first) t_r1 = $realtime;
    shin = {shin[6:0], mosi};
    rb++;
    if (rb == 8) begin
      got_q.push_back(shin);
      rb = 0; bytec++;
    end
  end
  always @(negedge sck) begin
    logic [7:0] b;
    t_lastfall = $realtime;
    if (first) begin t_f1 = $realtime; first = 0; end
    b = resp(bytec);
    miso = b[7-rb];
  end
  always @(posedge cs_n) t_csrise = $realtime;

  // monitor
  initial forever begin
    logic [7:0] g;
    wait (got_q.size() != 0);
    g = got_q.pop_front();
    if (exp_q.size() == 0) chk("R6 unexpected byte", g, 8'hxx);
    else chk("R6 mosi byte", g, exp_q.pop_front());
  end

  task automatic bus_wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic port_wr(logic [7:0] d);
    bus_wr(4'hC, d);
    ring_m[ptr_m] = d; ptr_m = (ptr_m + 1) % 8;
  endtask

  task automatic port_rd_chk(string tag);
    logic [7:0] v;
    bus_rd(4'hC, v);
    chk(tag, v, ring_m[ptr_m]);
    ptr_m = (ptr_m + 1) % 8;
  endtask

  task automatic rewind();
    bus_wr(4'h2, 8'h10); ptr_m = 0;
  endtask

  task automatic chk_sts(string tag);
    logic [7:0] v;
    bus_rd(4'hD, v);
    chk(tag, v, 8'((spd_m << 4) | ptr_m));
  endtask

  task automatic xfer(logic [7:0] opc, int tx, int rx, bit clr, bit poke);
    logic [7:0] v;
    int p0, half;
    bus_wr(4'h1, 8'((rx << 4) | tx));
    bus_wr(4'h0, opc);
    if (clr) ptr_m = 0;
    p0 = ptr_m;
    seed = opc ^ 8'((tx << 4) | rx);
    exp_q.push_back(opc);
    for (int j = 0; j < tx; j++) exp_q.push_back(ring_m[(p0 + j) % 8]);
    for (int j = 0; j < rx; j++) exp_q.push_back(8'h00);
    bus_wr(4'h2, clr ? 8'h11 : 8'h01);
    bus_rd(4'h2, v);
    chk("R4 busy set", v, 8'h01);
    if (poke) begin
      bus_wr(4'hC, 8'hEE);
      bus_wr(4'h2, 8'h10);
      bus_rd(4'hC, v);
      bus_wr(4'hD, 8'h30);
      bus_wr(4'h0, 8'h00);
      bus_wr(4'h1, 8'h00);
    end
    for (int i = 0; i < 4000; i++) begin
      bus_rd(4'h2, v);
      if (!v[0]) break;
    end
    chk("R4 busy clear", v, 8'h00);
    for (int k = 1; k <= tx + rx; k++) ring_m[(p0 + k - 1) % 8] = resp(k);
    ptr_m = (p0 + tx + rx) % 8;
    chk_sts("R7 end pointer");
    checks++;
    if (exp_q.size() != 0) begin
      fails++; $display("FAIL R6 missing bytes act=%0d exp=0", exp_q.size());
      exp_q.delete();
    end
    half = (spd_m + 1) * 5;
    checks++;
    if (int'(t_r1 - t_csf) != half || int'(t_f1 - t_r1) != half) begin
      fails++;
      $display("FAIL R8 R9 timing act=%0d/%0d exp=%0d", int'(t_r1 - t_csf), int'(t_f1 - t_r1), half);
    end
    checks++;
    if (t_csrise != t_lastfall) begin
      fails++; $display("FAIL R9 cs rise act=%0t exp=%0t", t_csrise, t_lastfall);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; fails++;
    $display("FAIL R4 watchdog act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R11
    chk("R11 cs", {7'b0, cs_n}, 8'h01);
    chk("R11 sck mosi", {6'b0, sck, mosi}, 8'h00);
    chk_sts("R11 status");
    bus_rd(4'h2, v); chk("R11 busy", v, 8'h00);
    // R1
    bus_wr(4'h0, 8'h9F); bus_wr(4'h1, 8'h21);
    bus_rd(4'h0, v); chk("R1 opcode", v, 8'h9F);
    bus_rd(4'h1, v); chk("R1 counts", v, 8'h21);
    // R2, R3
    port_wr(8'h11); port_wr(8'h22); port_wr(8'h33);
    chk_sts("R2 pointer after writes");
    rewind(); chk_sts("R3 pointer clear");
    port_rd_chk("R2 read 0"); port_rd_chk("R2 read 1"); port_rd_chk("R2 read 2");
    rewind();
    for (int i = 0; i < 8; i++) port_wr(8'hA0 + 8'(i));
    chk_sts("R2 pointer wrap");
    // basic transfer, fastest rate
    xfer(8'h03, 3, 2, 1'b0, 1'b0);
    rewind();
    for (int i = 0; i < 5; i++) port_rd_chk("R7 echo and data");
    // R8 slower rate
    bus_wr(4'hD, 8'h20); spd_m = 2; rewind(); chk_sts("R8 speed field");
    port_wr(8'h5C); rewind();
    xfer(8'h0B, 1, 4, 1'b0, 1'b0);
    // opcode only
    bus_wr(4'hD, 8'h30); spd_m = 3;
    xfer(8'h06, 0, 0, 1'b0, 1'b0);
    // R5 refused starts
    bus_wr(4'h1, 8'h06); bus_wr(4'h2, 8'h01);
    bus_rd(4'h2, v); chk("R5 tx limit busy", v, 8'h00);
    chk("R5 tx limit cs", {7'b0, cs_n}, 8'h01);
    bus_wr(4'h1, 8'h90); bus_wr(4'h2, 8'h01);
    repeat (3) @(negedge clk);
    chk("R5 rx limit cs", {7'b0, cs_n}, 8'h01);
    chk_sts("R5 pointer kept");
    // max counts wrap the ring
    bus_wr(4'hD, 8'h10); spd_m = 1; rewind();
    for (int i = 0; i < 5; i++) port_wr(8'h70 + 8'(i));
    rewind();
    xfer(8'h02, 5, 8, 1'b0, 1'b0);
    rewind();
    for (int i = 0; i < 8; i++) port_rd_chk("R7 wrapped slots");
    // R3 clear and start together
    port_wr(8'h44); port_wr(8'h55);
    xfer(8'h12, 2, 1, 1'b1, 1'b0);
    // R10 host activity during busy
    xfer(8'h3B, 0, 3, 1'b0, 1'b1);
    bus_rd(4'h0, v); chk("R10 opcode held", v, 8'h3B);
    bus_rd(4'h1, v); chk("R10 counts held", v, 8'h30);
    rewind();
    for (int i = 0; i < 8; i++) port_rd_chk("R10 ring intact");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule